// File: doc/BRIEF.md
# Dual-Path Digital PLL Loop Filter

This block is the digital loop filter of a phase-locked loop with a coarse and a fine oscillator tuning path. It takes one signed phase-error word from the time-to-digital converter on every reference clock. It produces three results: a coarse DAC code, a feedforward correction for the divider's sigma-delta input, and a fine DAC code.

A three-state sequencer runs the loop. The states are reset, acquisition and lock. During acquisition the coarse path integrates the phase error and sends a scaled copy of each error sample to the divider, while the fine DAC sits at mid-scale. Lock is reached once the error has stayed small for a set number of consecutive updates. At that point the coarse code is frozen, the quantization-noise-cancellation enable rises, and the fine path starts working.

The fine path has four stages:
- a saturating accumulator,
- a proportional (lead) term added to the accumulator output,
- a one-pole low-pass section with pole 1-2^-A_SH,
- a first-order noise-shaping truncator that cuts the FW-bit word down to the DAC width.

All gains are powers of two and are set by parameters.

Top module: `dpll_loop_filter`

## Requirements
- R1: While `rst` is high, every register clears. On the following cycle `mode` reads 0, `qnc_en` is 0, `div_ff` is 0, and both `fine_dac` and `coarse_dac` read mid-scale (2^(width-1)).
- R2: `mode` encodes reset=0, acquisition=1, lock=2 and never reads 3. From reset with `run` high it reads 1 after the next edge. Whenever `run` is low at an edge it reads 0 after that edge.
- R3: In acquisition, the state moves to lock on the edge that completes LOCK_CYC consecutive samples in which -LOCK_THR < `phase_err` < LOCK_THR. Any sample outside that band restarts the count. Lock can only be entered from acquisition.
- R4: Each edge taken in acquisition adds `phase_err` to a CACC_W-bit signed coarse accumulator, saturating at -2^(CACC_W-1) and 2^(CACC_W-1)-1. `coarse_dac` equals (accumulator >>> C_SH) + 2^(CDAC_W-1), clamped to 0..2^CDAC_W-1. Each edge taken in reset clears the accumulator.
- R5: In lock, `coarse_dac` holds its value. `qnc_en` is 1 exactly while `mode` reads 2.
- R6: After an edge taken in acquisition, `div_ff` equals `phase_err` >>> FF_SH (arithmetic shift). After any other edge it is 0.
- R7: `fine_dac` reads 2^(DAC_W-1) whenever `mode` did not read 2 at the previous edge.
- R8: On each edge taken in lock, the fine path updates in three steps:
  - the FACC_W-bit fine accumulator adds `phase_err` with saturation, giving F;
  - the lead-lag sum S = (F >>> K1_SH) + (`phase_err` <<< K2_SH) is clamped to FW signed bits;
  - the filter state Y is replaced by Y + ((S - Y) >>> A_SH).
  Outside lock, F and Y clear.
- R9: On each edge taken in lock, the truncator forms T = Y + 2^(FW-1) + residue. `fine_dac` becomes T >> (FW-DAC_W), clamped to 2^DAC_W-1, and the residue becomes the low FW-DAC_W bits of T. Outside lock the residue clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one filter update per edge |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Loop enable; low returns the sequencer to reset |
| phase_err | input | ERR_W | Signed phase-error sample from the TDC |
| mode | output | 2 | Sequencer state: 0 reset, 1 acquisition, 2 lock |
| qnc_en | output | 1 | Quantization-noise-cancellation enable, high in lock |
| coarse_dac | output | CDAC_W | Coarse tuning DAC code |
| div_ff | output | ERR_W | Signed feedforward word for the divider modulator |
| fine_dac | output | DAC_W | Fine tuning DAC code after noise-shaped truncation |

## Verification
Some faults show at once. A wrong lock counter shows as `mode` reaching 2 one or more cycles early or late against a bench model that counts qualifying samples itself. A wrong coarse accumulator changes `coarse_dac` on the cycle after the bad add, and a long run of full-scale error makes a wrap visible as a jump from the top code down. Other faults surface later. Errors in the fine accumulator, lead term or filter pole reach `fine_dac` one edge after the state is corrupted, because the truncator reads the registered filter output. A lost residue shows within a few cycles as a different code sequence under a constant small error. Saturation of the fine accumulator is only reached after a few hundred full-scale samples, so the bench holds the error at its limit for that long.

// File: rtl/dpll_lf_pkg.sv
package dpll_lf_pkg;

    typedef enum logic [1:0] {
        MODE_RESET = 2'd0,
        MODE_ACQ   = 2'd1,
        MODE_LOCK  = 2'd2
    } lf_mode_e;

    typedef struct packed {
        lf_mode_e mode;
        logic     qnc_en;
    } lf_ctrl_t;

    function automatic longint clamp_l(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    function automatic longint smax_l(input int w);
        return (longint'(1) <<< (w - 1)) - 1;
    endfunction

    function automatic longint smin_l(input int w);
        return -(longint'(1) <<< (w - 1));
    endfunction

endpackage

// File: rtl/dpll_lf_seq.sv
module dpll_lf_seq import dpll_lf_pkg::*; #(
    parameter int ERR_W    = 10,
    parameter int LOCK_THR = 8,
    parameter int LOCK_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic signed [ERR_W-1:0] phase_err,
    output lf_ctrl_t                ctrl
);
    localparam int CNT_W = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;

    logic [CNT_W-1:0] qual_cnt;
    logic             in_band;

    always_comb begin
        in_band = (longint'(phase_err) < longint'(LOCK_THR)) &&
                  (longint'(phase_err) > -longint'(LOCK_THR));
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ctrl.mode   <= MODE_RESET;
            ctrl.qnc_en <= 1'b0;
            qual_cnt    <= '0;
        end else begin
            case (ctrl.mode)
                MODE_RESET: begin
                    ctrl.mode   <= MODE_ACQ;
                    ctrl.qnc_en <= 1'b0;
                    qual_cnt    <= '0;
                end
                MODE_ACQ: begin
                    if (in_band) begin
                        if (qual_cnt == CNT_W'(LOCK_CYC - 1)) begin
                            ctrl.mode   <= MODE_LOCK;
                            ctrl.qnc_en <= 1'b1;
                            qual_cnt    <= '0;
                        end else begin
                            qual_cnt <= qual_cnt + 1'b1;
                        end
                    end else begin
                        qual_cnt <= '0;
                    end
                end
                MODE_LOCK: begin
                    ctrl.mode   <= MODE_LOCK;
                    ctrl.qnc_en <= 1'b1;
                end
                default: begin
                    ctrl.mode   <= MODE_RESET;
                    ctrl.qnc_en <= 1'b0;
                    qual_cnt    <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dpll_lf_coarse.sv
module dpll_lf_coarse import dpll_lf_pkg::*; #(
    parameter int ERR_W  = 10,
    parameter int CACC_W = 16,
    parameter int C_SH   = 4,
    parameter int CDAC_W = 10,
    parameter int FF_SH  = 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  lf_mode_e                mode,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic [CDAC_W-1:0]       coarse_dac,
    output logic signed [ERR_W-1:0] div_ff
);
    localparam longint CMID = longint'(1) <<< (CDAC_W - 1);
    localparam longint CTOP = (longint'(1) <<< CDAC_W) - 1;

    logic signed [CACC_W-1:0] cacc;
    longint                   cacc_sum;
    longint                   code;

    always_comb begin
        cacc_sum = clamp_l(longint'(cacc) + longint'(phase_err), smin_l(CACC_W), smax_l(CACC_W));
        code     = clamp_l((longint'(cacc) >>> C_SH) + CMID, 0, CTOP);
    end

    assign coarse_dac = CDAC_W'(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            cacc   <= '0;
            div_ff <= '0;
        end else begin
            case (mode)
                MODE_ACQ: begin
                    cacc   <= CACC_W'(cacc_sum);
                    div_ff <= phase_err >>> FF_SH;
                end
                MODE_LOCK: begin
                    div_ff <= '0;
                end
                default: begin
                    cacc   <= '0;
                    div_ff <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/dpll_lf_fine.sv
module dpll_lf_fine import dpll_lf_pkg::*; #(
    parameter int ERR_W  = 10,
    parameter int FACC_W = 18,
    parameter int K1_SH  = 6,
    parameter int K2_SH  = 2,
    parameter int A_SH   = 3,
    parameter int FW     = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  lf_mode_e                mode,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic signed [FW-1:0]    fine_word
);
    logic signed [FACC_W-1:0] facc;
    longint                   facc_n;
    longint                   lead_lag;
    longint                   iir_n;

    always_comb begin
        facc_n   = clamp_l(longint'(facc) + longint'(phase_err), smin_l(FACC_W), smax_l(FACC_W));
        lead_lag = clamp_l((facc_n >>> K1_SH) + (longint'(phase_err) <<< K2_SH),
                           smin_l(FW), smax_l(FW));
        iir_n    = longint'(fine_word) + ((lead_lag - longint'(fine_word)) >>> A_SH);
    end

    always_ff @(posedge clk) begin
        if (rst || mode != MODE_LOCK) begin
            facc      <= '0;
            fine_word <= '0;
        end else begin
            facc      <= FACC_W'(facc_n);
            fine_word <= FW'(iir_n);
        end
    end
endmodule

// File: rtl/dpll_lf_sdm.sv
module dpll_lf_sdm import dpll_lf_pkg::*; #(
    parameter int FW    = 16,
    parameter int DAC_W = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  lf_mode_e             mode,
    input  logic signed [FW-1:0] fine_word,
    output logic [DAC_W-1:0]     fine_dac
);
    localparam int     DROP = FW - DAC_W;
    localparam longint HALF = longint'(1) <<< (FW - 1);
    localparam longint DTOP = (longint'(1) <<< DAC_W) - 1;
    localparam logic [DAC_W-1:0] DMID = DAC_W'(longint'(1) <<< (DAC_W - 1));

    generate
        if (DROP > 0) begin : g_shaped
            logic [DROP-1:0] resid;
            longint          total;
            longint          quant;

            always_comb begin
                total = longint'(fine_word) + HALF + longint'(resid);
                quant = clamp_l(total >>> DROP, 0, DTOP);
            end

            always_ff @(posedge clk) begin
                if (rst || mode != MODE_LOCK) begin
                    resid    <= '0;
                    fine_dac <= DMID;
                end else begin
                    resid    <= DROP'(total);
                    fine_dac <= DAC_W'(quant);
                end
            end
        end else begin : g_direct
            longint quant;

            always_comb begin
                quant = clamp_l(longint'(fine_word) + HALF, 0, DTOP);
            end

            always_ff @(posedge clk) begin
                if (rst || mode != MODE_LOCK) begin
                    fine_dac <= DMID;
                end else begin
                    fine_dac <= DAC_W'(quant);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter import dpll_lf_pkg::*; #(
    parameter int ERR_W    = 10,
    parameter int CACC_W   = 16,
    parameter int C_SH     = 4,
    parameter int CDAC_W   = 10,
    parameter int FF_SH    = 1,
    parameter int FACC_W   = 18,
    parameter int K1_SH    = 6,
    parameter int K2_SH    = 2,
    parameter int A_SH     = 3,
    parameter int FW       = 16,
    parameter int DAC_W    = 10,
    parameter int LOCK_THR = 8,
    parameter int LOCK_CYC = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    run,
    input  logic signed [ERR_W-1:0] phase_err,
    output logic [1:0]              mode,
    output logic                    qnc_en,
    output logic [CDAC_W-1:0]       coarse_dac,
    output logic signed [ERR_W-1:0] div_ff,
    output logic [DAC_W-1:0]        fine_dac
);
    lf_ctrl_t                 ctrl;
    logic signed [FW-1:0]     fine_word;

    dpll_lf_seq #(
        .ERR_W(ERR_W), .LOCK_THR(LOCK_THR), .LOCK_CYC(LOCK_CYC)
    ) u_seq (
        .clk(clk), .rst(rst), .run(run), .phase_err(phase_err), .ctrl(ctrl)
    );

    dpll_lf_coarse #(
        .ERR_W(ERR_W), .CACC_W(CACC_W), .C_SH(C_SH), .CDAC_W(CDAC_W), .FF_SH(FF_SH)
    ) u_coarse (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .phase_err(phase_err),
        .coarse_dac(coarse_dac), .div_ff(div_ff)
    );

    dpll_lf_fine #(
        .ERR_W(ERR_W), .FACC_W(FACC_W), .K1_SH(K1_SH), .K2_SH(K2_SH), .A_SH(A_SH), .FW(FW)
    ) u_fine (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .phase_err(phase_err), .fine_word(fine_word)
    );

    dpll_lf_sdm #(
        .FW(FW), .DAC_W(DAC_W)
    ) u_sdm (
        .clk(clk), .rst(rst), .mode(ctrl.mode), .fine_word(fine_word), .fine_dac(fine_dac)
    );

    assign mode   = ctrl.mode;
    assign qnc_en = ctrl.qnc_en;
endmodule

// File: rtl/dpll_lf_chk.sv
module dpll_lf_chk #(
    parameter int ERR_W  = 10,
    parameter int CDAC_W = 10,
    parameter int DAC_W  = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    run,
    input logic [1:0]              mode,
    input logic                    qnc_en,
    input logic [CDAC_W-1:0]       coarse_dac,
    input logic signed [ERR_W-1:0] div_ff,
    input logic [DAC_W-1:0]        fine_dac
);
    localparam logic [DAC_W-1:0] FMID = DAC_W'(longint'(1) <<< (DAC_W - 1));

    // R1: reset forces the idle output state one cycle later
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (mode == 2'd0 && !qnc_en && div_ff == '0 && fine_dac == FMID));

    // R2: no illegal state code
    p_mode_legal_r2: assert property (@(posedge clk) disable iff (rst)
        mode != 2'd3);

    // R2: reset with run high proceeds to acquisition
    p_reset_to_acq_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 && run) |=> mode == 2'd1);

    // R3: lock is only entered from acquisition
    p_lock_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(mode) == 2'd1);

    // R5: coarse code frozen while locked
    p_coarse_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && $past(mode) == 2'd2) |-> $stable(coarse_dac));

    // R5: cancellation enable tracks lock
    p_qnc_lock_r5: assert property (@(posedge clk) disable iff (rst)
        qnc_en == (mode == 2'd2));

    // R6: divider feedforward silent outside acquisition
    p_div_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        $past(mode) != 2'd1 |-> div_ff == '0);

    // R7: fine code parked at mid-scale outside lock
    p_fine_mid_r7: assert property (@(posedge clk) disable iff (rst)
        $past(mode) != 2'd2 |-> fine_dac == FMID);
endmodule

bind dpll_loop_filter dpll_lf_chk #(
    .ERR_W(ERR_W), .CDAC_W(CDAC_W), .DAC_W(DAC_W)
) u_chk (
    .clk(clk), .rst(rst), .run(run), .mode(mode), .qnc_en(qnc_en),
    .coarse_dac(coarse_dac), .div_ff(div_ff), .fine_dac(fine_dac)
);

// File: tb/dpll_loop_filter_tb.sv
`timescale 1ns/1ps
module dpll_loop_filter_tb;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic signed [9:0] phase_err = '0;
    logic [1:0]        mode;
    logic              qnc_en;
    logic [9:0]        coarse_dac;
    logic signed [9:0] div_ff;
    logic [9:0]        fine_dac;

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state (values after the most recent edge)
    int     m_mode = 0;
    int     m_cnt  = 0;
    longint m_cacc = 0;
    longint m_div  = 0;
    longint m_facc = 0;
    longint m_y    = 0;
    longint m_res  = 0;
    longint m_dac  = 512;
    int     lock_seen_cycle = -1;
    int     acq_start_cycle = -1;
    int     cyc_no = 0;

    always #5 clk = ~clk;

    dpll_loop_filter u_dut (
        .clk(clk), .rst(rst), .run(run), .phase_err(phase_err),
        .mode(mode), .qnc_en(qnc_en), .coarse_dac(coarse_dac),
        .div_ff(div_ff), .fine_dac(fine_dac)
    );

    function automatic longint lim(input longint v, input longint lo, input longint hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc_no, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2/R3 mode", longint'(mode), longint'(m_mode));
        check("R5 qnc_en", longint'(qnc_en), (m_mode == 2) ? 1 : 0);
        check("R4 coarse_dac", longint'(coarse_dac), lim((m_cacc >>> 4) + 512, 0, 1023));
        check("R6 div_ff", longint'(div_ff), m_div);
        check("R8/R9 fine_dac", longint'(fine_dac), m_dac);
    endtask

    task automatic model_step(input logic r, input logic rn, input longint e);
        int     old;
        longint t;
        longint f;
        longint s;
        if (r) begin
            m_mode = 0; m_cnt = 0; m_cacc = 0; m_div = 0;
            m_facc = 0; m_y = 0; m_res = 0; m_dac = 512;
            return;
        end
        old = m_mode;
        if (old == 1) begin
            m_cacc = lim(m_cacc + e, -32768, 32767);
            m_div  = e >>> 1;
        end else begin
            if (old == 0) m_cacc = 0;
            m_div = 0;
        end
        if (old == 2) begin
            t      = m_y + 32768 + m_res;
            m_dac  = lim(t >>> 6, 0, 1023);
            m_res  = t % 64;
            f      = lim(m_facc + e, -131072, 131071);
            s      = lim((f >>> 6) + (e <<< 2), -32768, 32767);
            m_y    = m_y + ((s - m_y) >>> 3);
            m_facc = f;
        end else begin
            m_facc = 0; m_y = 0; m_res = 0; m_dac = 512;
        end
        if (!rn) begin
            m_mode = 0; m_cnt = 0;
        end else if (old == 0) begin
            m_mode = 1; m_cnt = 0;
        end else if (old == 1) begin
            if (e > -8 && e < 8) begin
                if (m_cnt == 15) begin m_mode = 2; m_cnt = 0; end
                else m_cnt++;
            end else begin
                m_cnt = 0;
            end
        end
    endtask

    task automatic step(input logic r, input logic rn, input longint e);
        @(negedge clk);
        compare_all();
        rst       = r;
        run       = rn;
        phase_err = 10'(e);
        model_step(r, rn, e);
        cyc_no++;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset phase
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0);
        @(negedge clk);
        check("R1 reset mode", longint'(mode), 0);
        check("R1 reset fine_dac", longint'(fine_dac), 512);
        check("R1 reset coarse_dac", longint'(coarse_dac), 512);
        check("R1 reset div_ff", longint'(div_ff), 0);
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 0);

        // R4: large positive error drives the coarse code to its top (saturation)
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, 500);
        @(negedge clk);
        check("R4 coarse_dac top clamp", longint'(coarse_dac), 1023);
        check("R7 fine_dac mid in acquisition", longint'(fine_dac), 512);
        // R4/R6: negative ramp, with occasional in-band samples that do not lock
        for (int i = 0; i < 100; i++) step(1'b0, 1'b1, -300 + (i % 7) * 50);
        // R3: short in-band run broken by a large sample restarts the count
        for (int i = 0; i < 10; i++) step(1'b0, 1'b1, (i % 2) ? 3 : -5);
        step(1'b0, 1'b1, 100);
        acq_start_cycle = cyc_no;
        for (int i = 0; i < 30; i++) begin
            step(1'b0, 1'b1, (i % 15) - 7);
            if (lock_seen_cycle < 0 && mode == 2'd2) lock_seen_cycle = cyc_no;
        end
        // R3: lock observed LOCK_CYC samples after the restart, sampled one edge later
        check("R3 lock latency", longint'(lock_seen_cycle - acq_start_cycle), 17);

        // R8/R9: lock with several error patterns
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, 3);
        for (int i = 0; i < 60; i++) step(1'b0, 1'b1, -(i % 9));
        for (int i = 0; i < 300; i++) step(1'b0, 1'b1, 511);
        for (int i = 0; i < 100; i++) step(1'b0, 1'b1, -511);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b1, (i % 5) * 60 - 120);

        // R2: run low returns to reset; run high relocks
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 0);
        @(negedge clk);
        check("R2 run low gives reset", longint'(mode), 0);
        check("R7 fine_dac mid after lock exit", longint'(fine_dac), 512);
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, (i % 3) - 1);
        @(negedge clk);
        check("R3 relock", longint'(mode), 2);

        // R1: reset in the middle of lock
        for (int i = 0; i < 2; i++) step(1'b1, 1'b1, 200);
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1, 4 - (i % 9));
        step(1'b0, 1'b1, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule